// File: doc/BRIEF.md
# Vector Integer ALU with Sticky Overflow Record

This block is the integer and logical execution lane of a vector unit. An instruction is handed over with a single `start` pulse. The pulse carries a 16-bit opcode, an exception-enable bit, a destination register number, the vector length and a scalar operand. Once the instruction is taken, the block accepts one element pair per cycle on `elem_valid`. It returns one 64-bit result per accepted element on the following cycle, tagged with that element's index.

The operations are 32-bit add, subtract and signed multiply, the bitwise operations OR, bit clear and XOR, and logical shifts left and right. The first operand is either the incoming vector element or the scalar, which is broadcast to every element. A signed overflow in add, subtract or multiply never stops the instruction: the truncated low 32 bits are written and the rest of the elements still run. When the instruction's exception-enable bit is set, the overflow is also logged in a sticky record. The record keeps an overflow flag and a mask of destination registers, and it holds its contents until `exc_clear` is asserted. The register file that supplies the elements, and the fetch of the instructions, sit outside this block.

Top module: `vec_int_alu`

## Requirements
- R1: An opcode is legal only when bits 7:0 equal 0xFD. With bit 8 cleared, bits 15:8 select the operation: 0x80 add, 0x88 subtract, 0xA0 multiply, 0xC8 OR, 0xCC bit clear, 0xE8 XOR, 0xE0 shift right, 0xE4 shift left. Bit 8 set selects the scalar as first operand A; bit 8 cleared selects `elem_a`. A `start` carrying any other opcode is ignored, and `busy` stays low.
- R2: A `start` while idle, with a legal opcode and 1 <= `vlen` <= MAX_VL, raises `busy` on the next cycle. `busy` stays high until `vlen` elements have been accepted. `start` while busy is ignored, and so is a `vlen` of 0 or above MAX_VL. `elem_valid` while idle produces no result.
- R3: Add gives A + B and subtract gives A - B, each on bits 31:0 only, keeping the low 32 bits of the exact result.
- R4: Multiply keeps the low 32 bits of the signed 64-bit product of A[31:0] and B[31:0].
- R5: OR gives A | B, bit clear gives B & ~A and XOR gives A ^ B, each on bits 31:0. Result bits 63:32 equal `elem_b` bits 63:32.
- R6: A shift moves B[31:0] right or left by A[4:0] positions and fills the vacated positions with zeros.
- R7: For add, subtract, multiply and both shifts, result bits 63:32 are zero.
- R8: `res_valid` is high in the cycle after an element is accepted. `res_idx` counts the accepted elements of the instruction, starting at 0.
- R9: A signed overflow in add, subtract or multiply with exception-enable set sets `exc_ovf` and the mask bit of the destination register. With exception-enable cleared it leaves the record unchanged. In both cases the element result is still the truncated value and the remaining elements still complete.
- R10: The record accumulates over instructions until `exc_clear`. An overflow logged in the same cycle as `exc_clear` is kept.
- R11: While reset is asserted, `busy`, `res_valid`, `exc_ovf` and `exc_dst_mask` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Instruction hand-over strobe |
| opcode | input | 16 | Instruction encoding |
| exc_en | input | 1 | Log overflows for this instruction |
| dst_reg | input | 4 | Destination register number |
| vlen | input | 7 | Number of elements |
| scalar | input | 32 | Broadcast first operand |
| elem_valid | input | 1 | Element pair present |
| elem_a | input | 32 | First operand element (low half) |
| elem_b | input | 64 | Second operand element |
| exc_clear | input | 1 | Clear the overflow record |
| busy | output | 1 | Instruction in progress |
| res_valid | output | 1 | Result present |
| res_data | output | 64 | Result element |
| res_idx | output | 7 | Element index of the result |
| exc_ovf | output | 1 | Sticky overflow flag |
| exc_dst_mask | output | 16 | Sticky mask of destination registers |

## Verification
`busy` follows an accepted `start` by one cycle. Each result, together with its index, appears one cycle after the edge that accepted its element. The overflow record changes on that same edge. The bench's reference model advances on each rising edge from the same inputs the design sees, and every output is compared on the falling edge that follows, so each expected value is due exactly when it is read.

// File: rtl/vialu_pkg.sv
package vialu_pkg;

   typedef enum logic [2:0] {
      OP_ADD,
      OP_SUB,
      OP_MUL,
      OP_OR,
      OP_BIC,
      OP_XOR,
      OP_SRL,
      OP_SLL
   } vop_e;

   localparam logic [7:0] OPC_TAG = 8'hFD;

   function automatic logic op_is_arith(input vop_e op);
      return (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL);
   endfunction

   function automatic logic op_is_logic(input vop_e op);
      return (op == OP_OR) || (op == OP_BIC) || (op == OP_XOR);
   endfunction

endpackage

// File: rtl/vialu_decode.sv
module vialu_decode
   import vialu_pkg::*;
(
   input  logic [15:0] opcode,
   output logic        legal,
   output vop_e        op,
   output logic        use_scalar
);

   logic [7:0] sel;

   always_comb begin
      sel        = {opcode[15:9], 1'b0};
      use_scalar = opcode[8];
      legal      = 1'b0;
      op         = OP_ADD;
      if (opcode[7:0] == OPC_TAG) begin
         legal = 1'b1;
         case (sel)
            8'h80:   op = OP_ADD;
            8'h88:   op = OP_SUB;
            8'hA0:   op = OP_MUL;
            8'hC8:   op = OP_OR;
            8'hCC:   op = OP_BIC;
            8'hE8:   op = OP_XOR;
            8'hE0:   op = OP_SRL;
            8'hE4:   op = OP_SLL;
            default: legal = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/vialu_lane.sv
module vialu_lane
   import vialu_pkg::*;
#(
   parameter int HALF_W      = 32,
   parameter int SHIFT_STYLE = 1,
   localparam int ELEM_W     = 2 * HALF_W,
   localparam int SH_W       = $clog2(HALF_W)
) (
   input  vop_e              op,
   input  logic [HALF_W-1:0] a,
   input  logic [ELEM_W-1:0] b,
   output logic [ELEM_W-1:0] res,
   output logic              ovf
);

   logic [HALF_W-1:0] b_lo;
   logic [HALF_W-1:0] sum, dif, srl_v, sll_v;
   logic signed [ELEM_W-1:0] sa, sb, prod;
   logic ovf_add, ovf_sub, ovf_mul;
   logic [HALF_W:0] prod_hi;

   assign b_lo = b[HALF_W-1:0];
   assign sum  = a + b_lo;
   assign dif  = a - b_lo;
   assign ovf_add = (a[HALF_W-1] == b_lo[HALF_W-1]) && (sum[HALF_W-1] != a[HALF_W-1]);
   assign ovf_sub = (a[HALF_W-1] != b_lo[HALF_W-1]) && (dif[HALF_W-1] != a[HALF_W-1]);

   assign sa      = {{HALF_W{a[HALF_W-1]}}, a};
   assign sb      = {{HALF_W{b_lo[HALF_W-1]}}, b_lo};
   assign prod    = sa * sb;
   assign prod_hi = prod[ELEM_W-1:HALF_W-1];
   assign ovf_mul = !((&prod_hi) || !(|prod_hi));

   generate
      if (SHIFT_STYLE == 0) begin : g_shift_op
         assign srl_v = b_lo >> a[SH_W-1:0];
         assign sll_v = b_lo << a[SH_W-1:0];
      end else begin : g_shift_barrel
         logic [HALF_W-1:0] rstg [SH_W+1];
         logic [HALF_W-1:0] lstg [SH_W+1];
         assign rstg[0] = b_lo;
         assign lstg[0] = b_lo;
         for (genvar g = 0; g < SH_W; g++) begin : g_stage
            localparam int AMT = 1 << g;
            assign rstg[g+1] = a[g] ? (rstg[g] >> AMT) : rstg[g];
            assign lstg[g+1] = a[g] ? (lstg[g] << AMT) : lstg[g];
         end
         assign srl_v = rstg[SH_W];
         assign sll_v = lstg[SH_W];
      end
   endgenerate

   always_comb begin
      res = '0;
      ovf = 1'b0;
      case (op)
         OP_ADD: begin res[HALF_W-1:0] = sum;               ovf = ovf_add; end
         OP_SUB: begin res[HALF_W-1:0] = dif;               ovf = ovf_sub; end
         OP_MUL: begin res[HALF_W-1:0] = prod[HALF_W-1:0];  ovf = ovf_mul; end
         OP_OR:  res = {b[ELEM_W-1:HALF_W], a | b_lo};
         OP_BIC: res = {b[ELEM_W-1:HALF_W], b_lo & ~a};
         OP_XOR: res = {b[ELEM_W-1:HALF_W], a ^ b_lo};
         OP_SRL: res[HALF_W-1:0] = srl_v;
         OP_SLL: res[HALF_W-1:0] = sll_v;
         default: res = '0;
      endcase
   end

endmodule

// File: rtl/vialu_exc_log.sv
module vialu_exc_log #(
   parameter int NREG    = 16,
   localparam int REG_W  = $clog2(NREG)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             event_v,
   input  logic [REG_W-1:0] dst,
   output logic             ovf,
   output logic [NREG-1:0]  mask
);

   logic [NREG-1:0] hit;

   assign hit = event_v ? (NREG'(1) << dst) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf  <= 1'b0;
         mask <= '0;
      end else begin
         ovf  <= (ovf & ~clear) | event_v;
         mask <= (clear ? '0 : mask) | hit;
      end
   end

endmodule

// File: rtl/vec_int_alu.sv
module vec_int_alu
   import vialu_pkg::*;
#(
   parameter int HALF_W      = 32,
   parameter int NREG        = 16,
   parameter int MAX_VL      = 64,
   parameter int SHIFT_STYLE = 1,
   localparam int ELEM_W     = 2 * HALF_W,
   localparam int REG_W      = $clog2(NREG),
   localparam int VL_W       = $clog2(MAX_VL + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [15:0]       opcode,
   input  logic              exc_en,
   input  logic [REG_W-1:0]  dst_reg,
   input  logic [VL_W-1:0]   vlen,
   input  logic [HALF_W-1:0] scalar,
   input  logic              elem_valid,
   input  logic [HALF_W-1:0] elem_a,
   input  logic [ELEM_W-1:0] elem_b,
   input  logic              exc_clear,
   output logic              busy,
   output logic              res_valid,
   output logic [ELEM_W-1:0] res_data,
   output logic [VL_W-1:0]   res_idx,
   output logic              exc_ovf,
   output logic [NREG-1:0]   exc_dst_mask
);

   generate
      if (HALF_W < 8 || (HALF_W & (HALF_W - 1)) != 0) begin : g_bad_half
         $error("HALF_W must be a power of two of at least 8");
      end
      if (NREG < 2 || MAX_VL < 1) begin : g_bad_size
         $error("NREG must be at least 2 and MAX_VL at least 1");
      end
   endgenerate

   logic              dec_legal, dec_scal;
   vop_e              dec_op;
   logic              start_ok, accept, last_elem;
   logic              busy_q, sel_scal_q, en_q;
   vop_e              op_q;
   logic [HALF_W-1:0] scal_q, a_opnd;
   logic [REG_W-1:0]  dst_q;
   logic [VL_W-1:0]   len_q, cnt_q;
   logic [ELEM_W-1:0] lane_res;
   logic              lane_ovf;

   vialu_decode u_dec (
      .opcode     (opcode),
      .legal      (dec_legal),
      .op         (dec_op),
      .use_scalar (dec_scal)
   );

   assign start_ok  = start && !busy_q && dec_legal &&
                      (vlen != '0) && (vlen <= VL_W'(MAX_VL));
   assign accept    = busy_q && elem_valid;
   assign last_elem = (cnt_q == len_q - VL_W'(1));
   assign a_opnd    = sel_scal_q ? scal_q : elem_a;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         op_q       <= OP_ADD;
         sel_scal_q <= 1'b0;
         en_q       <= 1'b0;
         scal_q     <= '0;
         dst_q      <= '0;
         len_q      <= '0;
         cnt_q      <= '0;
      end else if (start_ok) begin
         busy_q     <= 1'b1;
         op_q       <= dec_op;
         sel_scal_q <= dec_scal;
         en_q       <= exc_en;
         scal_q     <= scalar;
         dst_q      <= dst_reg;
         len_q      <= vlen;
         cnt_q      <= '0;
      end else if (accept) begin
         cnt_q <= cnt_q + VL_W'(1);
         if (last_elem) busy_q <= 1'b0;
      end
   end

   vialu_lane #(
      .HALF_W      (HALF_W),
      .SHIFT_STYLE (SHIFT_STYLE)
   ) u_lane (
      .op  (op_q),
      .a   (a_opnd),
      .b   (elem_b),
      .res (lane_res),
      .ovf (lane_ovf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_data  <= '0;
         res_idx   <= '0;
      end else begin
         res_valid <= accept;
         if (accept) begin
            res_data <= lane_res;
            res_idx  <= cnt_q;
         end
      end
   end

   vialu_exc_log #(.NREG(NREG)) u_exc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (exc_clear),
      .event_v (accept && en_q && lane_ovf),
      .dst     (dst_q),
      .ovf     (exc_ovf),
      .mask    (exc_dst_mask)
   );

   assign busy = busy_q;

endmodule

// File: rtl/vialu_chk.sv
module vialu_chk
   import vialu_pkg::*;
#(
   parameter int HALF_W = 32
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  busy,
   input logic                  res_valid,
   input logic                  elem_valid,
   input logic                  exc_ovf,
   input logic                  exc_clear,
   input logic [2*HALF_W-1:0]   res_data,
   input vop_e                  op_q,
   input logic                  en_q,
   input logic                  start_ok
);

   // R2: an accepted instruction makes the block busy on the next cycle
   p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_ok |=> busy);

   // R8: every result comes from an element accepted one cycle earlier
   p_result_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(busy && elem_valid));

   // R7: arithmetic and shift results carry a zero upper half
   p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !op_is_logic(op_q)) |-> (res_data[2*HALF_W-1:HALF_W] == '0));

   // R10: the overflow flag only drops on a clear
   p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_ovf && !exc_clear) |=> exc_ovf);

   // R9: the flag rises only from an enabled arithmetic element
   p_log_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(exc_ovf) |-> $past(busy && elem_valid && en_q && op_is_arith(op_q)));

   // R11: reset leaves the block idle
   p_reset_idle_r11: assert property (@(posedge clk)
      !rst_n |=> (!busy && !res_valid && !exc_ovf));

endmodule

bind vec_int_alu vialu_chk #(.HALF_W(HALF_W)) u_vialu_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy),
   .res_valid  (res_valid),
   .elem_valid (elem_valid),
   .exc_ovf    (exc_ovf),
   .exc_clear  (exc_clear),
   .res_data   (res_data),
   .op_q       (op_q),
   .en_q       (en_q),
   .start_ok   (start_ok)
);

// File: tb/test_vec_int_alu.sv
module test_vec_int_alu;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] opcode = '0;
   logic        exc_en = 1'b0;
   logic [3:0]  dst_reg = '0;
   logic [6:0]  vlen = '0;
   logic [31:0] scalar = '0;
   logic        elem_valid = 1'b0;
   logic [31:0] elem_a = '0;
   logic [63:0] elem_b = '0;
   logic        exc_clear = 1'b0;
   logic        busy, res_valid, exc_ovf;
   logic [63:0] res_data;
   logic [6:0]  res_idx;
   logic [15:0] exc_dst_mask;

   int n_tests = 0;
   int n_fail  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vec_int_alu i_vec_int_alu (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .exc_en(exc_en),
      .dst_reg(dst_reg), .vlen(vlen), .scalar(scalar), .elem_valid(elem_valid),
      .elem_a(elem_a), .elem_b(elem_b), .exc_clear(exc_clear), .busy(busy),
      .res_valid(res_valid), .res_data(res_data), .res_idx(res_idx),
      .exc_ovf(exc_ovf), .exc_dst_mask(exc_dst_mask)
   );

   // ---------------- behavioural reference model ----------------
   bit          m_busy, m_en, m_rv, m_ovf;
   int          m_hi, m_len, m_cnt, m_dst, m_ri;
   logic [31:0] m_sc;
   logic [63:0] m_rd;
   logic [15:0] m_mask;

   function automatic bit legal_opc(input logic [15:0] o);
      int h;
      h = int'(o[15:8]) & 'hFE;
      return (o[7:0] == 8'hFD) &&
             (h == 'h80 || h == 'h88 || h == 'hA0 || h == 'hC8 ||
              h == 'hCC || h == 'hE8 || h == 'hE0 || h == 'hE4);
   endfunction

   function automatic string tag_of(input int h);
      case (h & 'hFE)
         'h80, 'h88: return "R3";
         'hA0:       return "R4";
         'hE0, 'hE4: return "R6";
         default:    return "R5";
      endcase
   endfunction

   function automatic bit is_logic(input int h);
      int e;
      e = h & 'hFE;
      return e == 'hC8 || e == 'hCC || e == 'hE8;
   endfunction

   task automatic ref_calc(input int h, input logic [31:0] a, input logic [63:0] b,
                           output logic [63:0] r, output bit ov);
      longint sa, sb, t;
      sa = longint'($signed(a));
      sb = longint'($signed(b[31:0]));
      t  = 0;
      ov = 1'b0;
      r  = '0;
      case (h & 'hFE)
         'h80: t = sa + sb;
         'h88: t = sa - sb;
         'hA0: t = sa * sb;
         default: t = 0;
      endcase
      case (h & 'hFE)
         'h80, 'h88, 'hA0: begin
            r  = {32'h0, t[31:0]};
            ov = (t > 64'sd2147483647) || (t < -64'sd2147483648);
         end
         'hC8: r = {b[63:32], a | b[31:0]};
         'hCC: r = {b[63:32], b[31:0] & ~a};
         'hE8: r = {b[63:32], a ^ b[31:0]};
         'hE0: r = {32'h0, b[31:0] >> a[4:0]};
         'hE4: r = {32'h0, b[31:0] << a[4:0]};
         default: r = '0;
      endcase
   endtask

   always @(posedge clk) begin
      logic [63:0] r;
      logic [31:0] a;
      bit          ov, evt;
      evt = 1'b0;
      if (!rst_n) begin
         m_busy = 0; m_rv = 0; m_ovf = 0; m_mask = '0; m_cnt = 0; m_ri = 0; m_rd = '0;
      end else begin
         m_rv = 0;
         if (m_busy && elem_valid) begin
            a = m_hi[0] ? m_sc : elem_a;
            ref_calc(m_hi, a, elem_b, r, ov);
            m_rd = r; m_rv = 1; m_ri = m_cnt;
            m_cnt++;
            if (m_cnt == m_len) m_busy = 0;
            evt = ov && m_en;
         end else if (!m_busy && start && legal_opc(opcode) &&
                      vlen >= 1 && vlen <= 64) begin
            m_busy = 1; m_hi = int'(opcode[15:8]); m_en = exc_en;
            m_dst = int'(dst_reg); m_len = int'(vlen); m_sc = scalar; m_cnt = 0;
         end
         if (exc_clear) begin m_ovf = 0; m_mask = '0; end
         if (evt) begin m_ovf = 1; m_mask[m_dst] = 1'b1; end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // per-cycle comparison on the falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk(busy == m_busy, "R2", "busy", 64'(busy), 64'(m_busy));
         chk(res_valid == m_rv, "R8", "res_valid", 64'(res_valid), 64'(m_rv));
         if (m_rv && res_valid) begin
            chk(res_data[31:0] == m_rd[31:0], tag_of(m_hi), "low half",
                64'(res_data[31:0]), 64'(m_rd[31:0]));
            chk(res_data[63:32] == m_rd[63:32], is_logic(m_hi) ? "R5" : "R7",
                "upper half", 64'(res_data[63:32]), 64'(m_rd[63:32]));
            chk(int'(res_idx) == m_ri, "R8", "res_idx", 64'(res_idx), 64'(m_ri));
         end
         chk(exc_ovf == m_ovf, "R9", "exc_ovf", 64'(exc_ovf), 64'(m_ovf));
         chk(exc_dst_mask == m_mask, "R10", "exc_dst_mask",
             64'(exc_dst_mask), 64'(m_mask));
      end
   end

   // ---------------- stimulus ----------------
   logic [31:0] va [64];
   logic [63:0] vb [64];

   task automatic do_op(input logic [15:0] opc, input bit en, input int dst, input int n,
                        input logic [31:0] sc, input bit gaps, input bit clr0);
      @(negedge clk);
      start = 1; opcode = opc; exc_en = en; dst_reg = 4'(dst); vlen = 7'(n); scalar = sc;
      @(negedge clk);
      start = 0; exc_en = 0;
      for (int i = 0; i < n; i++) begin
         elem_valid = 1; elem_a = va[i]; elem_b = vb[i];
         exc_clear = clr0 && (i == 0);
         if (gaps && i == 1) begin start = 1; opcode = 16'hE8FD; vlen = 7'd3; end
         @(negedge clk);
         start = 0; exc_clear = 0;
         if (gaps) begin elem_valid = 0; @(negedge clk); end
      end
      if (gaps) begin elem_valid = 1; elem_a = 32'h5; elem_b = 64'h9; @(negedge clk); end
      elem_valid = 0;
      @(negedge clk);
   endtask

   task automatic try_reject(input logic [15:0] opc, input int n, input string req);
      @(negedge clk);
      start = 1; opcode = opc; vlen = 7'(n);
      @(negedge clk);
      start = 0;
      chk(busy == 1'b0, req, "rejected start leaves idle", 64'(busy), 64'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      chk(busy == 0 && res_valid == 0, "R11", "idle in reset", 64'({busy, res_valid}), 64'h0);
      chk(exc_ovf == 0 && exc_dst_mask == 0, "R11", "record clear in reset",
          64'(exc_dst_mask), 64'h0);
      rst_n = 1;
      @(negedge clk);
      // R2: element while idle gives no result
      elem_valid = 1; elem_a = 32'h1; elem_b = 64'h2;
      @(negedge clk);
      elem_valid = 0;
      chk(res_valid == 0, "R2", "idle element dropped", 64'(res_valid), 64'h0);
      // R1: illegal opcodes; R2: bad lengths
      try_reject(16'h80FE, 2, "R1");
      try_reject(16'h82FD, 2, "R1");
      try_reject(16'h80FD, 0, "R2");
      try_reject(16'h80FD, 65, "R2");

      // R3/R9: vector add with overflow logging to register 3
      va[0] = 32'h1;        vb[0] = 64'hAAAA_0000_0000_0002;
      va[1] = 32'h7FFF_FFFF; vb[1] = 64'h1234_0000_0000_0001;
      va[2] = 32'hFFFF_FFFF; vb[2] = 64'h0000_0001_0000_0001;
      va[3] = 32'h8000_0000; vb[3] = 64'h0000_0000_FFFF_FFFF;
      do_op(16'h80FD, 1, 3, 4, 32'h0, 0, 0);
      chk(exc_ovf == 1 && exc_dst_mask == 16'h0008, "R9", "add overflow logged",
          64'(exc_dst_mask), 64'h0008);

      // R3/R9: scalar subtract overflow, logging disabled, gaps and start while busy
      vb[0] = 64'h1; vb[1] = 64'hFFFF_FFFF; vb[2] = 64'h8000_0000;
      do_op(16'h89FD, 0, 7, 3, 32'h8000_0000, 1, 0);
      chk(exc_dst_mask == 16'h0008, "R9", "disabled overflow not logged",
          64'(exc_dst_mask), 64'h0008);

      // R4: multiply with overflow logged to register 5
      va[0] = 32'h0001_0000; vb[0] = 64'h0001_0000;
      va[1] = 32'hFFFF_FFFD; vb[1] = 64'h7;
      va[2] = 32'h7FFF_FFFF; vb[2] = 64'h2;
      va[3] = 32'hFFFF_FFFF; vb[3] = 64'hFFFF_FFFF;
      do_op(16'hA0FD, 1, 5, 4, 32'h0, 0, 0);
      chk(exc_dst_mask == 16'h0028, "R10", "record accumulates", 64'(exc_dst_mask), 64'h0028);

      // R5: logical operations keep the upper half of B
      for (int i = 0; i < 4; i++) begin
         va[i] = 32'hF0F0_0000 + 32'(i * 'h1111);
         vb[i] = {32'hC0DE_0000 + 32'(i), 32'h0FF0_F00F ^ 32'(i << 8)};
      end
      do_op(16'hC9FD, 1, 1, 4, 32'h00FF_00FF, 0, 0);
      do_op(16'hCCFD, 1, 1, 4, 32'h0, 0, 0);
      do_op(16'hE9FD, 1, 1, 4, 32'hFFFF_0000, 0, 0);

      // R6: shifts, scalar count 33 uses only bits 4:0
      for (int i = 0; i < 4; i++) vb[i] = {32'hDEAD_BEEF, 32'h8000_0001 + 32'(i)};
      do_op(16'hE1FD, 1, 1, 4, 32'd33, 0, 0);
      va[0] = 32'd0; va[1] = 32'd31; va[2] = 32'd5; va[3] = 32'd16;
      do_op(16'hE4FD, 1, 1, 4, 32'h0, 0, 0);
      do_op(16'hE0FD, 1, 1, 4, 32'h0, 0, 0);
      chk(exc_dst_mask == 16'h0028, "R9", "logic/shift never log", 64'(exc_dst_mask), 64'h0028);

      // R10: clear alone, then clear together with a new event
      @(negedge clk); exc_clear = 1; @(negedge clk); exc_clear = 0;
      chk(exc_ovf == 0 && exc_dst_mask == 0, "R10", "clear empties record",
          64'(exc_dst_mask), 64'h0);
      va[0] = 32'h7FFF_FFFF; vb[0] = 64'h7FFF_FFFF;
      do_op(16'h80FD, 1, 2, 1, 32'h0, 0, 1);
      chk(exc_ovf == 1 && exc_dst_mask == 16'h0004, "R10", "event beside clear kept",
          64'(exc_dst_mask), 64'h0004);

      // R2/R8: maximum length instruction
      for (int i = 0; i < 64; i++) begin
         va[i] = 32'(i * 32'h0301_0107);
         vb[i] = 64'(i) * 64'h0000_0101_1003_0405;
      end
      do_op(16'h88FD, 0, 9, 64, 32'h0, 0, 0);
      chk(busy == 0, "R2", "idle after full length", 64'(busy), 64'h0);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule